// File: doc/BRIEF.md
# Serial Port Error Status and Interrupt Unit

This unit collects the error conditions of one serial port half. It has three sources. The primary data lane and the secondary data lane each deliver a single-cycle error pulse. The third source is a built-in guard that notices a frame sync arriving while a word is still being shifted. Each source sets a sticky status bit. Software clears a status bit by writing a one to it.

A mask register holds one enable per source. The unit raises a single level-sensitive interrupt request whenever an enabled source has its status bit set. The request stays high until software clears the offending status bits or masks them.

The guard keeps its own bit counter within the current word. The counter advances on every serial bit tick and wraps after the programmed word length. Every frame sync restarts the counter, whether or not that frame sync is premature.

Access goes through a small register port with one address bit:
- Address 0 selects the status register.
- Address 1 selects the mask register.

Reads are combinational from the address.

Top module: `sp_err_stat`

## Requirements
- R1: After reset, the status register reads 0, the mask register reads 0 and `irq` is low.
- R2: A pulse on `pri_err` sets status bit 0 at the next clock edge, and the bit stays set until it is cleared.
- R3: A pulse on `sec_err` sets status bit 1 at the next clock edge, and the bit stays set until it is cleared.
- R4: A `fs_evt` pulse sets status bit 2 at the next clock edge only when the word bit counter is non-zero and below `word_len`. A frame sync that arrives at count zero sets nothing.
- R5: The word bit counter advances by one on each `bit_tick`. It returns to 0 on the tick that would bring it to `word_len`. A `fs_evt` in any cycle forces it to 0, and a tick in that same cycle is discarded.
- R6: A write to address 0 clears each status bit whose write-data bit is 1. A status bit whose write-data bit is 0 keeps its value.
- R7: When an error event for a status bit and a write-one-to-clear of that bit land in the same cycle, the bit ends up set.
- R8: A write to address 1 loads mask bits [2:0] from write data. The bit order is the same as the status register: bit 0 primary, bit 1 secondary, bit 2 frame sync. The new mask is in force from the next cycle. Register bits above bit 2 read as 0.
- R9: `irq` is high exactly when some status bit and its mask bit are both set. It stays high until those status bits are cleared or masked.
- R10: `reg_rdata` shows the register selected by `reg_addr` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_err | input | 1 | Primary lane error pulse |
| sec_err | input | 1 | Secondary lane error pulse |
| fs_evt | input | 1 | Frame sync event pulse |
| bit_tick | input | 1 | One serial bit shifted |
| word_len | input | CW | Programmed bits per word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = mask |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is a frame sync landing at an exact bit position inside a word, for each word length. The counter cannot be observed directly.

The bench therefore first sends a frame sync to restart the count and clears any error that frame sync produced. It then issues a chosen number of bit ticks and sends a second frame sync. It sweeps word lengths 1 to 6 and tick counts from 0 to beyond one full word. The expected error follows from the tick count modulo the word length.

The interrupt logic is checked over every combination of status contents and mask values.

// File: rtl/sp_err_pkg.sv
package sp_err_pkg;
  localparam int NSRC = 3;
  typedef enum int {
    SRC_PRI = 0,
    SRC_SEC = 1,
    SRC_FS  = 2
  } src_e;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_MASK = 1'b1;
endpackage

// File: rtl/sp_fs_guard.sv
module sp_fs_guard #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_evt,
  input  logic          bit_tick,
  input  logic [CW-1:0] word_len,
  output logic          early_fs
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic          cnt_en;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign cnt_en  = fs_evt | bit_tick;

  always_comb begin
    cnt_d = cnt_q;
    if (fs_evt) begin
      cnt_d = '0;
    end else if (bit_tick) begin
      if (cnt_inc >= {1'b0, word_len}) cnt_d = '0;
      else                             cnt_d = cnt_inc[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign early_fs = fs_evt && (cnt_q != '0) && (cnt_q < word_len);

  // R5
  fs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_evt |=> (cnt_q == '0));
  // R5
  tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !fs_evt && (cnt_inc < {1'b0, word_len}))
      |=> (cnt_q == $past(cnt_inc[CW-1:0])));
endmodule

// File: rtl/sp_sticky_bit.sv
module sp_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (set_evt)      q_d = 1'b1;
    else if (clr_req) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> q);
  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !q);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !set_evt) |=> $stable(q));
endmodule

// File: rtl/sp_err_stat.sv
module sp_err_stat
  import sp_err_pkg::*;
#(
  parameter int CW = 5,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pri_err,
  input  logic          sec_err,
  input  logic          fs_evt,
  input  logic          bit_tick,
  input  logic [CW-1:0] word_len,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          irq
);
  localparam int PADW = RW - NSRC;

  logic            early_fs;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            stat_wr, mask_wr;

  sp_fs_guard #(.CW(CW)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_evt   (fs_evt),
    .bit_tick (bit_tick),
    .word_len (word_len),
    .early_fs (early_fs)
  );

  assign evt[SRC_PRI] = pri_err;
  assign evt[SRC_SEC] = sec_err;
  assign evt[SRC_FS]  = early_fs;

  assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
  assign mask_wr = reg_wr && (reg_addr == ADDR_MASK);
  assign clr     = stat_wr ? reg_wdata[NSRC-1:0] : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    sp_sticky_bit u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (evt[i]),
      .clr_req (clr[i]),
      .q       (stat_q[i])
    );
  end

  assign mask_d = reg_wdata[NSRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_d;
  end

  always_comb begin
    if (reg_addr == ADDR_MASK) reg_rdata = {{PADW{1'b0}}, mask_q};
    else                       reg_rdata = {{PADW{1'b0}}, stat_q};
  end

  assign irq = |(stat_q & mask_q);

  // R2
  pri_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_err |=> stat_q[SRC_PRI]);
  // R3
  sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_err |=> stat_q[SRC_SEC]);
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(reg_wdata[NSRC-1:0])));
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);
endmodule

// File: tb/sp_err_stat_test.sv
`timescale 1ns/1ps
module sp_err_stat_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pri_err, sec_err, fs_evt, bit_tick;
  logic [4:0] word_len;
  logic       reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  sp_err_stat uut (
    .clk(clk), .rst_n(rst_n), .pri_err(pri_err), .sec_err(sec_err),
    .fs_evt(fs_evt), .bit_tick(bit_tick), .word_len(word_len),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_fs();
    @(negedge clk); fs_evt = 1'b1;
    @(negedge clk); fs_evt = 1'b0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); bit_tick = 1'b1;
    end
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic make_fs_err();
    word_len = 5'd4;
    pulse_fs();
    ticks(1);
    pulse_fs();
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pri_err = 0; sec_err = 0; fs_evt = 0; bit_tick = 0;
    word_len = 5'd8; reg_wr = 0; reg_addr = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, rv); chk("R1 status", rv, 0);
    rd(1'b1, rv); chk("R1 mask", rv, 0);
    chk("R1 irq", irq, 0);

    // R2 / R3 set and stickiness
    @(negedge clk); pri_err = 1;
    @(negedge clk); pri_err = 0;
    rd(1'b0, rv); chk("R2 pri set", rv, 1);
    repeat (3) @(negedge clk);
    rd(1'b0, rv); chk("R2 pri sticky", rv, 1);
    @(negedge clk); sec_err = 1;
    @(negedge clk); sec_err = 0;
    rd(1'b0, rv); chk("R3 sec set", rv, 3);

    // R6 write-one-to-clear / write zero keeps; R10 read mux
    wr(1'b0, 8'h00);
    rd(1'b0, rv); chk("R6 write zero keeps", rv, 3);
    wr(1'b0, 8'h01);
    rd(1'b0, rv); chk("R6 clear pri only", rv, 2);
    wr(1'b0, 8'hFF);
    rd(1'b0, rv); chk("R6 clear all", rv, 0);

    // R7 set beats clear
    @(negedge clk);
    pri_err = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 8'h01;
    @(negedge clk);
    pri_err = 0; reg_wr = 0; reg_wdata = 0;
    rd(1'b0, rv); chk("R7 set priority", rv, 1);
    wr(1'b0, 8'h07);

    // R8 mask register, upper bits read zero
    wr(1'b1, 8'hFD);
    rd(1'b1, rv); chk("R8 mask load", rv, 5);
    rd(1'b0, rv); chk("R10 status via addr0", rv, 0);
    wr(1'b1, 8'h00);

    // R4 / R5 premature frame sync sweep
    for (int wl = 1; wl <= 6; wl++) begin
      for (int k = 0; k <= wl + 2; k++) begin
        word_len = wl[4:0];
        pulse_fs();
        wr(1'b0, 8'h07);
        if (k > 0) ticks(k);
        pulse_fs();
        rd(1'b0, rv);
        chk($sformatf("R4 R5 fs err wl=%0d k=%0d", wl, k),
            rv, ((k % wl) != 0) ? 4 : 0);
      end
    end
    wr(1'b0, 8'h07);

    // R5 tick discarded when coincident with frame sync
    word_len = 5'd3;
    pulse_fs();
    ticks(1);
    @(negedge clk); fs_evt = 1; bit_tick = 1;
    @(negedge clk); fs_evt = 0; bit_tick = 0;
    wr(1'b0, 8'h07);
    pulse_fs();
    rd(1'b0, rv); chk("R5 tick dropped on fs", rv, 0);

    // R9 exhaustive status x mask
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 8; m++) begin
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h07);
        if (s[2]) make_fs_err();
        if (s[0] || s[1]) begin
          @(negedge clk); pri_err = s[0]; sec_err = s[1];
          @(negedge clk); pri_err = 0; sec_err = 0;
        end
        rd(1'b0, rv); chk($sformatf("R9 status s=%0d", s), rv, s);
        chk("R9 irq masked off", irq, 0);
        wr(1'b1, m[7:0]);
        chk($sformatf("R8 R9 irq s=%0d m=%0d", s, m), irq, ((s & m) != 0) ? 1 : 0);
      end
    end

    // R9 irq stays until cleared
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h02);
    @(negedge clk); sec_err = 1;
    @(negedge clk); sec_err = 0;
    repeat (4) @(negedge clk);
    chk("R9 irq held", irq, 1);
    wr(1'b0, 8'h01);
    chk("R9 irq after clearing other bit", irq, 1);
    wr(1'b0, 8'h02);
    chk("R9 irq dropped", irq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule